// File: doc/BRIEF.md
# Twin-Mask Compress/Expand Index Sequencer

This block walks two element pointers across a vector of up to 64 elements and produces a stream of (source index, destination index) pairs. Each pair stands for one element move of a single-source, single-destination operation. Each pointer has its own predicate mask. The source pointer jumps over elements whose source-mask bit is clear, and the destination pointer jumps over elements whose destination-mask bit is clear. The result is a compress step followed by an expand step in one pass. When the source mask is all ones the pass is a pure expand. When the destination mask is all ones it is a pure compress.

Each side carries a scalar/vector tag. A scalar side keeps its index at element 0. A scalar destination ends the pass after the first pair, which gives a select of one element. A scalar source with a vector destination gives a broadcast or an insert. A pulse on `start_i` latches the element count and both masks. The pairs then come out on a valid/ready handshake, at most one per cycle. Each skip search is a single-cycle priority scan, so the next pair is ready in the cycle after the previous one is accepted. A one-cycle `done_o` pulse marks the end of the pass. The block moves no data and holds no register file.

Top module: `twin_pred_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `pair_valid_o` and `done_o` are all 0.
- R2: With a vector source, each emitted source index has its bit set in the latched source mask (bit k of the mask is element k). It is the lowest such index at or above one past the previous emitted source index, starting from 0.
- R3: With a vector destination, each emitted destination index has its bit set in the latched destination mask. It is the lowest such index at or above one past the previous emitted destination index, starting from 0.
- R4: A scalar side always presents index 0, and its mask has no effect.
- R5: With a scalar destination, exactly one pair is emitted if any pair is possible. `done_o` is 1 in the cycle after that pair is accepted, and `busy_o` is 0 in that same cycle.
- R6: The pass ends when either side's search finds no set mask bit below the element count. This includes the case where no pair at all is emitted. `done_o` then pulses for exactly one cycle, and `busy_o` falls in that same cycle.
- R7: While `pair_valid_o` is 1 and `pair_ready_i` is 0, the next cycle still shows `pair_valid_o` at 1 with both indices unchanged. A pair counts as transferred only in a cycle where both `pair_valid_o` and `pair_ready_i` are 1.
- R8: Mask bits at or above the element count are ignored. An element count of 0 ends the pass with no pair. A count above 64 is treated as 64.
- R9: `start_i` is ignored while `busy_o` is 1. The latched count, masks and tags do not change, and the pair stream continues unchanged. Input changes after the start cycle likewise have no effect.
- R10: With all-ones masks on both vector sides, the pairs are (k, k) for k from 0 to count-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a pass when the block is idle |
| vl_i | input | 7 | Element count, 0 to 64 |
| src_mask_i | input | 64 | Source predicate mask, bit k for element k |
| dst_mask_i | input | 64 | Destination predicate mask, bit k for element k |
| src_vec_i | input | 1 | 1: source is a vector, 0: scalar |
| dst_vec_i | input | 1 | 1: destination is a vector, 0: scalar |
| pair_valid_o | output | 1 | An index pair is presented |
| pair_ready_i | input | 1 | Consumer accepts the presented pair |
| src_idx_o | output | 6 | Source element index of the pair |
| dst_idx_o | output | 6 | Destination element index of the pair |
| busy_o | output | 1 | A pass is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a pass |

## Verification
A start seen at a rising edge makes `busy_o` high from that edge. From then on the first pair, if there is one, is combinational on the latched state and can be seen half a cycle later. A pair accepted at an edge moves both pointers at that edge, so the next pair can be seen in the next cycle. `done_o` comes one edge after the cycle in which the pass ends, either the cycle with no pair or the accepting cycle of a scalar destination. The bench drives and samples only on falling edges. It records a pair only when valid and ready were both high before the next rising edge, and it compares the ordered list against its own model when `done_o` is seen. Stall cycles are checked one sample later for an unchanged pair.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef enum logic {
    TP_IDLE = 1'b0,
    TP_RUN  = 1'b1
  } tp_state_e;
endpackage

// File: rtl/tp_side_ptr.sv
module tp_side_ptr #(
  parameter int MAX_VL = 64,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              vec_i,
  input  logic [MAX_VL-1:0] mask_i,
  input  logic [CNT_W-1:0]  vl_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              hit_o
);

  // lowest set mask bit in [from, vl); result is {found, index}
  function automatic logic [IDX_W:0] scan_from(
    input logic [MAX_VL-1:0] mask,
    input logic [CNT_W-1:0]  from,
    input logic [CNT_W-1:0]  vl
  );
    logic             found;
    logic [IDX_W-1:0] pos;
    found = 1'b0;
    pos   = '0;
    for (int k = MAX_VL - 1; k >= 0; k--) begin
      if (mask[k] && (CNT_W'(k) >= from) && (CNT_W'(k) < vl)) begin
        found = 1'b1;
        pos   = IDX_W'(k);
      end
    end
    return {found, pos};
  endfunction

  logic [CNT_W-1:0] ptr_q;
  logic [IDX_W:0]   scan;

  assign scan = scan_from(mask_i, ptr_q, vl_i);

  always_comb begin
    if (vec_i) begin
      hit_o = scan[IDX_W];
      idx_o = scan[IDX_W-1:0];
    end else begin
      hit_o = (vl_i != '0);
      idx_o = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (load_i) begin
      ptr_q <= '0;
    end else if (adv_i && vec_i) begin
      ptr_q <= {1'b0, idx_o} + CNT_W'(1);
    end
  end

endmodule

// File: rtl/twin_pred_seq.sv
module twin_pred_seq #(
  parameter int MAX_VL = 64,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  vl_i,
  input  logic [MAX_VL-1:0] src_mask_i,
  input  logic [MAX_VL-1:0] dst_mask_i,
  input  logic              src_vec_i,
  input  logic              dst_vec_i,
  output logic              pair_valid_o,
  input  logic              pair_ready_i,
  output logic [IDX_W-1:0]  src_idx_o,
  output logic [IDX_W-1:0]  dst_idx_o,
  output logic              busy_o,
  output logic              done_o
);
  import tp_pkg::*;

  function automatic logic [CNT_W-1:0] clamp_vl(input logic [CNT_W-1:0] v);
    return (v > CNT_W'(MAX_VL)) ? CNT_W'(MAX_VL) : v;
  endfunction

  tp_state_e         state_q;
  logic [CNT_W-1:0]  vl_q;
  logic [MAX_VL-1:0] smask_q, dmask_q;
  logic              svec_q, dvec_q;
  logic              done_q;

  logic start_take, pair_fire, seq_end, s_hit, d_hit;

  assign busy_o       = (state_q == TP_RUN);
  assign start_take   = (state_q == TP_IDLE) && start_i;
  assign pair_valid_o = busy_o && s_hit && d_hit;
  assign pair_fire    = pair_valid_o && pair_ready_i;
  assign seq_end      = busy_o && (!(s_hit && d_hit) || (pair_fire && !dvec_q));
  assign done_o       = done_q;

  // one pointer per side
  for (genvar g = 0; g < 2; g++) begin : g_side
    logic              vec_w, hit_w;
    logic [MAX_VL-1:0] mask_w;
    logic [IDX_W-1:0]  idx_w;
    assign vec_w  = (g == 0) ? svec_q : dvec_q;
    assign mask_w = (g == 0) ? smask_q : dmask_q;
    tp_side_ptr #(.MAX_VL(MAX_VL)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start_take),
      .adv_i  (pair_fire),
      .vec_i  (vec_w),
      .mask_i (mask_w),
      .vl_i   (vl_q),
      .idx_o  (idx_w),
      .hit_o  (hit_w)
    );
  end

  assign s_hit     = g_side[0].hit_w;
  assign d_hit     = g_side[1].hit_w;
  assign src_idx_o = g_side[0].idx_w;
  assign dst_idx_o = g_side[1].idx_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TP_IDLE;
      vl_q    <= '0;
      smask_q <= '0;
      dmask_q <= '0;
      svec_q  <= 1'b0;
      dvec_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= seq_end;
      if (start_take) begin
        state_q <= TP_RUN;
        vl_q    <= clamp_vl(vl_i);
        smask_q <= src_mask_i;
        dmask_q <= dst_mask_i;
        svec_q  <= src_vec_i;
        dvec_q  <= dst_vec_i;
      end else if (seq_end) begin
        state_q <= TP_IDLE;
      end
    end
  end

endmodule

// File: rtl/tp_seq_chk.sv
module tp_seq_chk #(
  parameter int MAX_VL = 64,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int CNT_W = IDX_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              pair_valid_o,
  input logic              pair_ready_i,
  input logic [IDX_W-1:0]  src_idx_o,
  input logic [IDX_W-1:0]  dst_idx_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [CNT_W-1:0]  vl_q,
  input logic [MAX_VL-1:0] smask_q,
  input logic [MAX_VL-1:0] dmask_q,
  input logic              svec_q,
  input logic              dvec_q
);

  p_src_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid_o && svec_q |-> smask_q[src_idx_o]);

  p_src_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid_o && pair_ready_i && svec_q |=>
      !pair_valid_o || (src_idx_o > $past(src_idx_o)));

  p_dst_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid_o && dvec_q |-> dmask_q[dst_idx_o]);

  p_scalar_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid_o && !svec_q |-> src_idx_o == '0);

  p_scalar_dst_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid_o && pair_ready_i && !dvec_q |=> done_o && !busy_o);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !pair_valid_o);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid_o && !pair_ready_i |=>
      pair_valid_o && $stable(src_idx_o) && $stable(dst_idx_o));

  p_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid_o |-> ({1'b0, src_idx_o} < vl_q) && ({1'b0, dst_idx_o} < vl_q));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=>
      $stable(vl_q) && $stable(smask_q) && $stable(dmask_q) &&
      $stable(svec_q) && $stable(dvec_q));

endmodule

bind twin_pred_seq tp_seq_chk #(.MAX_VL(MAX_VL)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .pair_valid_o (pair_valid_o),
  .pair_ready_i (pair_ready_i),
  .src_idx_o    (src_idx_o),
  .dst_idx_o    (dst_idx_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .vl_q         (vl_q),
  .smask_q      (smask_q),
  .dmask_q      (dmask_q),
  .svec_q       (svec_q),
  .dvec_q       (dvec_q)
);

// File: tb/sim_twin_pred_seq.sv
module sim_twin_pred_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [6:0]  vl_i = '0;
  logic [63:0] src_mask_i = '0, dst_mask_i = '0;
  logic        src_vec_i = 1'b0, dst_vec_i = 1'b0;
  logic        pair_valid_o, pair_ready_i = 1'b0;
  logic [5:0]  src_idx_o, dst_idx_o;
  logic        busy_o, done_o;

  int n_run = 0;
  int n_fail = 0;
  int exp_s[65];
  int exp_d[65];
  int exp_n;

  always #10 clk = ~clk;

  twin_pred_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
    .src_mask_i(src_mask_i), .dst_mask_i(dst_mask_i),
    .src_vec_i(src_vec_i), .dst_vec_i(dst_vec_i),
    .pair_valid_o(pair_valid_o), .pair_ready_i(pair_ready_i),
    .src_idx_o(src_idx_o), .dst_idx_o(dst_idx_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // reference: list of pairs from the two masks
  task automatic build_model(input int vl, input logic [63:0] sm, input logic [63:0] dm,
                             input bit sv, input bit dv);
    int i = 0;
    int j = 0;
    int lim = (vl > 64) ? 64 : vl;
    exp_n = 0;
    forever begin
      if (sv) while (i < lim && !sm[i]) i++;
      if (dv) while (j < lim && !dm[j]) j++;
      if (i >= lim || j >= lim) break;
      exp_s[exp_n] = i;
      exp_d[exp_n] = j;
      exp_n++;
      if (sv) i++;
      if (dv) j++;
      else break;
    end
  endtask

  task automatic run_seq(input string req, input int vl, input logic [63:0] sm,
                         input logic [63:0] dm, input bit sv, input bit dv,
                         input int ready_pct, input bit poke);
    int got = 0;
    int cyc = 0;
    bit stalled = 1'b0;
    logic [5:0] ps, pd;
    build_model(vl, sm, dm, sv, dv);
    @(negedge clk);
    vl_i = 7'(vl); src_mask_i = sm; dst_mask_i = dm;
    src_vec_i = sv; dst_vec_i = dv; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // scramble inputs: latched values must rule (R9)
    vl_i = 7'($urandom_range(64)); src_mask_i = {$urandom, $urandom};
    dst_mask_i = {$urandom, $urandom}; src_vec_i = ~sv; dst_vec_i = ~dv;
    forever begin
      if (done_o) break;
      if (cyc > 2000) begin
        check(1'b0, req, "pass did not finish", cyc, 0);
        break;
      end
      if (stalled)
        check(pair_valid_o && src_idx_o == ps && dst_idx_o == pd, "R7",
              "pair held during stall", {src_idx_o, dst_idx_o}, {ps, pd});
      start_i = (poke && cyc == 1 && busy_o);
      pair_ready_i = ($urandom_range(99) < ready_pct);
      stalled = pair_valid_o && !pair_ready_i;
      ps = src_idx_o; pd = dst_idx_o;
      if (pair_valid_o && pair_ready_i) begin
        if (got < exp_n) begin
          check(src_idx_o == exp_s[got], req, "source index", src_idx_o, exp_s[got]);
          check(dst_idx_o == exp_d[got], req, "destination index", dst_idx_o, exp_d[got]);
        end else begin
          check(1'b0, req, "extra pair", got + 1, exp_n);
        end
        got++;
      end
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0;
    pair_ready_i = 1'b0;
    check(got == exp_n, req, "pair count at end", got, exp_n);
    check(!busy_o, "R6", "busy low with done", busy_o, 0);
    @(negedge clk);
    check(!done_o, "R6", "done is one cycle", done_o, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #5;
    check(!busy_o && !pair_valid_o && !done_o, "R1", "state in reset",
          {busy_o, pair_valid_o, done_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !pair_valid_o && !done_o, "R1", "idle after reset",
          {busy_o, pair_valid_o, done_o}, 0);

    run_seq("R10", 8, '1, '1, 1, 1, 100, 0);
    run_seq("R10", 64, '1, '1, 1, 1, 100, 0);
    run_seq("R2", 16, 64'h0000_0000_0000_A4C1, '1, 1, 1, 100, 0);
    run_seq("R3", 16, '1, 64'h0000_0000_0000_9218, 1, 1, 100, 0);
    run_seq("R2/R3", 32, 64'h0000_0000_F00F_0550, 64'h0000_0000_8421_8421, 1, 1, 70, 0);
    run_seq("R5", 12, 64'h0000_0000_0000_0F00, '1, 1, 0, 100, 0);
    run_seq("R5", 12, '0, '1, 1, 0, 100, 0);
    run_seq("R4", 10, 64'h0, 64'h0000_0000_0000_0122, 0, 1, 100, 0);
    run_seq("R4", 10, '1, '1, 0, 0, 50, 0);
    run_seq("R6", 20, 64'h0000_0000_0000_0003, '1, 1, 1, 100, 0);
    run_seq("R6", 20, '1, 64'h0, 1, 1, 100, 0);
    run_seq("R8", 0, '1, '1, 1, 1, 100, 0);
    run_seq("R8", 8, 64'hFFFF_FFFF_FFFF_FF00, '1, 1, 1, 100, 0);
    run_seq("R8", 100, '1, 64'h8000_0000_0000_0001, 1, 1, 100, 0);
    run_seq("R7", 24, 64'h0000_0000_00AA_55AA, 64'h0000_0000_00F0_F0F0, 1, 1, 25, 0);
    run_seq("R9", 30, 64'h0000_0000_1357_9BDF, 64'h0000_0000_2468_ACE0, 1, 1, 40, 1);

    for (int t = 0; t < 60; t++) begin
      logic [63:0] sm = {$urandom, $urandom};
      logic [63:0] dm = {$urandom, $urandom};
      if (t % 3 == 0) sm = sm & {$urandom, $urandom};
      run_seq("R2/R3", $urandom_range(64), sm, dm, ($urandom_range(5) != 0),
              ($urandom_range(5) != 0), 30 + $urandom_range(70), (t % 7 == 0));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule